// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block decides which interrupt a 16550-style serial port reports. It holds the four-bit interrupt enable register and the hidden transmit-empty pending flag. From these and the live cause inputs it works out the identification byte and one active-high interrupt line. The cause inputs are the line error flags, the character-timeout pending flag, data-ready, the receive FIFO fill count and trigger level, and the modem delta bits.

The register file around it supplies access strobes. One strobe marks a write to the enable register. Another marks a read of the identification register. The transmit path pulses one input when the holding register drains and another when it is loaded. The identification byte and the interrupt line are decoded combinationally from registered state and the cause inputs, so the line falls in the same cycle its last cause goes away.

Top module: `uirq_resolver`

## Requirements
- R1: When several enabled causes are active, exactly one is reported, in this order of precedence: line error first, then character timeout, then received data, then transmit empty, then modem change.
- R2: The low nibble of the identification byte is 0x6 for line error, 0xC for timeout, 0x4 for received data, 0x2 for transmit empty and 0x0 for modem change. It is 0x1 when nothing enabled is pending.
- R3: A line-error cause needs enable bit 2 set and at least one bit of `line_err` set. The `line_err` bits are bit 0 overrun, bit 1 parity, bit 2 framing and bit 3 break.
- R4: The character-timeout cause is gated by enable bit 0, the received-data enable. No other enable bit gates it.
- R5: Received data needs enable bit 0 and `rx_ready`. With `fifo_on` high it also needs `rx_count` greater than or equal to `rx_trig`. With `fifo_on` low, `rx_ready` alone is enough.
- R6: Reading the identification register (`id_rd`) clears the transmit-empty pending flag at the next edge. The byte returned by that read still shows the cause.
- R7: The pending flag is set by `txe_set`, and also by an enable-register write while `thr_empty` is high. A set wins over a simultaneous `id_rd`. A holding-register load (`thr_load`) clears the flag and wins over both.
- R8: An enable-register write stores only data bits 3:0. `en_rdata` returns those bits with bits 7:4 reading zero.
- R9: Bits 7:6 of the identification byte are both 1 when `fifo_on` is high and both 0 otherwise. Bits 5:4 are always 0.
- R10: `irq` is high exactly when the low nibble of the identification byte is not 0x1, with no added cycle of delay.
- R11: After reset the enable register is zero, the pending flag is clear, and the identification byte is 0x01 with FIFOs off.
- R12: Modem change needs enable bit 3 and any bit of `msr_delta` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Enable-register write strobe |
| en_wdata | input | 8 | Enable-register write data |
| en_rdata | output | 8 | Enable-register read value |
| id_rd | input | 1 | Identification-register read strobe |
| thr_empty | input | 1 | Holding register currently empty |
| thr_load | input | 1 | Holding register written this cycle |
| txe_set | input | 1 | Holding register drained this cycle |
| fifo_on | input | 1 | FIFO mode enabled |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| rx_tmo | input | 1 | Character-timeout pending |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| msr_delta | input | 4 | Modem-status delta bits |
| id_byte | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench sweeps every value of the enable register against every combination of the five causes, with FIFO mode and fill count varied. This catches a design that swaps two priority levels, or that lets the timeout slip past a cleared bit 0. It also catches a design that gates the timeout with some other enable. A sweep of fill count against each trigger level probes the exact `>=` boundary; an off-by-one design reports one entry early or late. The pending flag is driven with `id_rd`, `txe_set`, `thr_load` and enable writes in the same cycle. A design with the wrong precedence would lose a drain event or keep a stale transmit-empty cause.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM  = 4'h0,
    ID_NONE   = 4'h1,
    ID_TXE    = 4'h2,
    ID_RXDATA = 4'h4,
    ID_LINE   = 4'h6,
    ID_TMO    = 4'hC
  } id_code_e;

  // cause index, 0 = highest precedence
  localparam int C_LINE  = 0;
  localparam int C_TMO   = 1;
  localparam int C_RXD   = 2;
  localparam int C_TXE   = 3;
  localparam int C_MODEM = 4;
  localparam int NCAUSE  = 5;

  function automatic id_code_e cause_code(input int idx);
    case (idx)
      C_LINE:  return ID_LINE;
      C_TMO:   return ID_TMO;
      C_RXD:   return ID_RXDATA;
      C_TXE:   return ID_TXE;
      default: return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en_q,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-EN_W){1'b0}}, {EN_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata[EN_W-1:0];
  end

  assign rdata = {{(DATA_W-EN_W){1'b0}}, en_q};

  a_r8_low_bits_only: assert property (@(posedge clk) disable iff (rst)
    wr |=> rdata == ($past(wdata) & LOW_MASK));

endmodule

// File: rtl/uirq_txe_flag.sv
module uirq_txe_flag (
  input  logic clk,
  input  logic rst,
  input  logic thr_load,
  input  logic txe_set,
  input  logic en_wr,
  input  logic thr_empty,
  input  logic id_rd,
  output logic pend
);
  logic set_req;
  assign set_req = txe_set | (en_wr & thr_empty);

  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (thr_load) pend <= 1'b0;
    else if (set_req)  pend <= 1'b1;
    else if (id_rd)    pend <= 1'b0;
  end

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (id_rd && !thr_load && !txe_set && !(en_wr && thr_empty)) |=> !pend);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (!thr_load && (txe_set || (en_wr && thr_empty))) |=> pend);

  a_r7_load_clears: assert property (@(posedge clk) disable iff (rst)
    thr_load |=> !pend);

endmodule

// File: rtl/uirq_rx_gate.sv
module uirq_rx_gate #(
  parameter int CNT_W = 5
) (
  input  logic             fifo_on,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  output logic             rx_req
);
  logic at_level;
  assign at_level = (rx_count >= rx_trig);
  assign rx_req   = rx_ready & (~fifo_on | at_level);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int NC = NCAUSE
) (
  input  logic [NC-1:0] req,
  output id_code_e      code,
  output logic          any
);
  always_comb begin
    code = ID_NONE;
    for (int i = NC-1; i >= 0; i--) begin
      if (req[i]) code = cause_code(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/uirq_resolver.sv
module uirq_resolver
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4,
  parameter int FIFO_D = 16,
  parameter int CNT_W  = $clog2(FIFO_D + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr,
  input  logic [DATA_W-1:0] en_wdata,
  output logic [DATA_W-1:0] en_rdata,
  input  logic              id_rd,
  input  logic              thr_empty,
  input  logic              thr_load,
  input  logic              txe_set,
  input  logic              fifo_on,
  input  logic [3:0]        line_err,
  input  logic              rx_tmo,
  input  logic              rx_ready,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  rx_trig,
  input  logic [3:0]        msr_delta,
  output logic [DATA_W-1:0] id_byte,
  output logic              irq
);
  localparam int EB_RX    = 0;
  localparam int EB_TX    = 1;
  localparam int EB_LINE  = 2;
  localparam int EB_MODEM = 3;

  logic [EN_W-1:0]   en_q;
  logic              txe_pend;
  logic              rx_req;
  logic [NCAUSE-1:0] req;
  id_code_e          code;
  logic              any;

  uirq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
    .clk(clk), .rst(rst), .wr(en_wr), .wdata(en_wdata),
    .en_q(en_q), .rdata(en_rdata));

  uirq_txe_flag u_txe (
    .clk(clk), .rst(rst), .thr_load(thr_load), .txe_set(txe_set),
    .en_wr(en_wr), .thr_empty(thr_empty), .id_rd(id_rd), .pend(txe_pend));

  uirq_rx_gate #(.CNT_W(CNT_W)) u_rx (
    .fifo_on(fifo_on), .rx_ready(rx_ready), .rx_count(rx_count),
    .rx_trig(rx_trig), .rx_req(rx_req));

  assign req[C_LINE]  = en_q[EB_LINE]  & (|line_err);
  assign req[C_TMO]   = en_q[EB_RX]    & rx_tmo;
  assign req[C_RXD]   = en_q[EB_RX]    & rx_req;
  assign req[C_TXE]   = en_q[EB_TX]    & txe_pend;
  assign req[C_MODEM] = en_q[EB_MODEM] & (|msr_delta);

  uirq_prio #(.NC(NCAUSE)) u_prio (.req(req), .code(code), .any(any));

  assign id_byte = {{2{fifo_on}}, {(DATA_W-6){1'b0}}, code};
  assign irq     = any;

  a_r1_line_first: assert property (@(posedge clk) disable iff (rst)
    (en_rdata[2] && |line_err) |-> id_byte[3:0] == 4'h6);

  a_r4_rx_enable_gates: assert property (@(posedge clk) disable iff (rst)
    !en_rdata[0] |-> (id_byte[3:0] != 4'hC && id_byte[3:0] != 4'h4));

  a_r5_below_trigger: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && rx_count < rx_trig && !rx_tmo) |-> id_byte[3:0] != 4'h4);

  a_r9_upper_bits: assert property (@(posedge clk) disable iff (rst)
    id_byte[7:4] == (fifo_on ? 4'hC : 4'h0));

  a_r10_line_matches_id: assert property (@(posedge clk) disable iff (rst)
    irq == (id_byte[3:0] != 4'h1));

endmodule

// File: tb/sim_uirq_resolver.sv
`timescale 1ns/100ps
module sim_uirq_resolver;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 0, id_rd = 0, thr_empty = 0, thr_load = 0, txe_set = 0;
  logic fifo_on = 0, rx_tmo = 0, rx_ready = 0;
  logic [7:0] en_wdata = 0;
  logic [3:0] line_err = 0, msr_delta = 0;
  logic [CNT_W-1:0] rx_count = 0, rx_trig = 0;
  logic [7:0] en_rdata, id_byte;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uirq_resolver u0 (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .id_rd(id_rd), .thr_empty(thr_empty), .thr_load(thr_load), .txe_set(txe_set),
    .fifo_on(fifo_on), .line_err(line_err), .rx_tmo(rx_tmo), .rx_ready(rx_ready),
    .rx_count(rx_count), .rx_trig(rx_trig), .msr_delta(msr_delta),
    .id_byte(id_byte), .irq(irq));

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // independent model of the identification byte
  function automatic logic [7:0] model(input logic [3:0] ie, input logic pend);
    logic [3:0] c;
    logic rxd;
    rxd = rx_ready && (!fifo_on || rx_count >= rx_trig);
    if      (ie[2] && line_err != 0)  c = 4'h6;
    else if (ie[0] && rx_tmo)         c = 4'hC;
    else if (ie[0] && rxd)            c = 4'h4;
    else if (ie[1] && pend)           c = 4'h2;
    else if (ie[3] && msr_delta != 0) c = 4'h0;
    else                              c = 4'h1;
    return {fifo_on, fifo_on, 2'b00, c};
  endfunction

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  task automatic chk_id(input string tag, input logic [3:0] ie, input logic pend);
    logic [7:0] e;
    #1;
    e = model(ie, pend);
    chk(tag, id_byte, e);
    chk({tag, " irq R10"}, {7'd0, irq}, {7'd0, e[3:0] != 4'h1});
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 0; #1;
    // R11 reset state
    chk("R11 enable after reset", en_rdata, 8'h00);
    chk("R11 id after reset", id_byte, 8'h01);
    chk("R11 irq after reset", {7'd0, irq}, 8'h00);
    wr_en(8'h02); #1;
    chk("R11 flag clear after reset", id_byte, 8'h01);

    // R8 write masking
    wr_en(8'hFF); #1; chk("R8 upper bits read zero", en_rdata, 8'h0F);
    wr_en(8'hA5); #1; chk("R8 low nibble stored", en_rdata, 8'h05);

    // R1 R2 R4 R12 full sweep of enables x causes
    for (int ie = 0; ie < 16; ie++) begin
      for (int m = 0; m < 32; m++) begin
        thr_empty = 0;
        wr_en(8'(ie));
        if (m[3]) begin txe_set = 1; tick(); txe_set = 0; end
        else      begin id_rd = 1;   tick(); id_rd = 0;   end
        fifo_on   = 1'((ie + m) % 2);
        line_err  = m[0] ? 4'(1 << (ie % 4)) : 4'h0;
        rx_tmo    = m[1];
        rx_ready  = m[2];
        msr_delta = m[4] ? 4'(1 << ((ie + 1) % 4)) : 4'h0;
        rx_trig   = 5'd8;
        rx_count  = (m % 3 == 0) ? 5'd2 : 5'd9;
        chk_id("R1 R2 R4 R12 sweep", 4'(ie), m[3]);
        line_err = 0; rx_tmo = 0; rx_ready = 0; msr_delta = 0;
      end
    end

    // R3 each error bit alone; R9 with fifo off
    wr_en(8'h04); fifo_on = 0;
    for (int b = 0; b < 4; b++) begin
      line_err = 4'(1 << b);
      chk_id("R3 single error bit", 4'h4, 1'b0);
    end
    line_err = 0;
    chk_id("R3 no error bit", 4'h4, 1'b0);

    // R5 threshold sweep
    wr_en(8'h01); rx_ready = 1;
    for (int t = 0; t < 4; t++) begin
      rx_trig = (t == 0) ? 5'd1 : (t == 1) ? 5'd4 : (t == 2) ? 5'd8 : 5'd14;
      for (int c = 0; c <= 16; c++) begin
        rx_count = 5'(c);
        fifo_on = 1; chk_id("R5 fifo trigger", 4'h1, 1'b0);
        fifo_on = 0; chk_id("R5 fifo off R9", 4'h1, 1'b0);
      end
    end
    rx_ready = 0; rx_count = 0;

    // R6 read returns cause, then clears
    wr_en(8'h02);
    txe_set = 1; tick(); txe_set = 0;
    id_rd = 1; #1; chk("R6 read sees txe", id_byte, 8'h02);
    tick(); id_rd = 0; #1;
    chk("R6 cleared after read", id_byte, 8'h01);

    // R7 enable write while holding empty
    thr_empty = 1; wr_en(8'h02); thr_empty = 0; #1;
    chk("R7 enable write sets flag", id_byte, 8'h02);
    // R7 set wins over read
    id_rd = 1; tick(); id_rd = 0; #1; chk("R7 read clears", id_byte, 8'h01);
    id_rd = 1; txe_set = 1; tick(); id_rd = 0; txe_set = 0; #1;
    chk("R7 set beats read", id_byte, 8'h02);
    // R7 load beats set
    thr_load = 1; txe_set = 1; tick(); thr_load = 0; txe_set = 0; #1;
    chk("R7 load beats set", id_byte, 8'h01);
    // R7 enable write with holding full leaves flag clear
    wr_en(8'h02); #1;
    chk("R7 write while full", id_byte, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule